// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status and Interrupt Routing

This block takes an asynchronous serial line and rebuilds frames from it. A frame is a low start bit, a data byte sent least-significant bit first, an optional parity bit and a high stop bit. The line is first passed through a synchronizer. It is then oversampled sixteen times per bit, using a tick from a programmable clock divider. Each received byte is placed in a receive buffer register. A buffer-full flag shows that this byte has not yet been taken by the host.

Three reception faults are recorded in a sticky status register:
- a parity mismatch,
- a stop bit sampled low,
- a new frame finishing while the buffer still holds an unread byte.

The host clears the whole status register by pulsing a status-read strobe. At the end of every frame the block pulses one of two interrupt lines. A routing input chooses the behaviour. With it clear, erroneous frames go to a dedicated error interrupt and clean frames go to the completion interrupt. With it set, every frame, erroneous or not, is reported on the completion interrupt.

Top module: `uart_rx_errroute`

## Requirements
- R1: The line is sampled on a tick every `baud_div_i` clocks (values 0 and 1 both mean every clock), sixteen ticks per bit. A falling line is accepted as a start bit only if it is still low at the eighth tick. A low pulse shorter than that starts no frame.
- R2: Data bits are sampled at the sixteenth tick of each bit period and assembled least-significant bit first. A completed frame loads `rx_data_o` and sets `buf_full_o` if the buffer is not full. A `rd_buf_i` pulse clears `buf_full_o` at the next edge.
- R3: `parity_mode_i` selects the parity bit: 0 = no parity bit, 1 = even, 2 = odd, 3 = always zero. A mismatch sets `stat_o[0]`. In mode 0 no parity bit is expected and `stat_o[0]` is never set.
- R4: A stop bit sampled low sets `stat_o[1]`. The byte is still delivered to the buffer.
- R5: A frame that completes while `buf_full_o` is set and `rd_buf_i` is low sets `stat_o[2]`. The earlier byte stays in `rx_data_o` and the new byte is dropped.
- R6: Status flags are sticky. A `rd_stat_i` pulse returns `stat_o` to zero at the next edge. If a frame completes at that same edge, only that frame's new flags remain.
- R7: With `err_merge_i` = 0, a frame with any fault pulses only `irq_err_o`, and a clean frame pulses only `irq_done_o`.
- R8: With `err_merge_i` = 1, every completed frame pulses `irq_done_o`, and `irq_err_o` stays low.
- R9: Each interrupt is a single-clock pulse. It is asserted one clock after the stop-bit sample, at the same edge that updates the buffer and the status register.
- R10: After reset `rx_data_o`, `buf_full_o`, `stat_o`, `irq_done_o` and `irq_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial input line, idle high |
| baud_div_i | input | DIV_W | Clocks per oversample tick |
| parity_mode_i | input | 2 | Parity selection (R3 encoding) |
| err_merge_i | input | 1 | 1 routes faults into the completion interrupt |
| rd_buf_i | input | 1 | Host read strobe for the receive buffer |
| rd_stat_i | input | 1 | Host read strobe for the status register, clears it |
| rx_data_o | output | DATA_W | Receive buffer register |
| buf_full_o | output | 1 | Buffer holds an unread byte |
| stat_o | output | 3 | {overrun, framing, parity} flags |
| irq_done_o | output | 1 | Reception-complete interrupt pulse |
| irq_err_o | output | 1 | Reception error interrupt pulse |

## Verification
With a divisor of 1, suppose the line falls just after edge k. The buffer, the status flags and the interrupt pulse then change together at edge k+27+16n, where n is the number of bit periods after the start bit (8, or 9 with parity). That count is two synchronizer stages, the start-bit check and the stop-bit sample, plus one output register. Host read strobes take effect at the first edge they are present.

The bench schedules each frame's expected result for its exact edge and steps its model at every edge. It compares all outputs two time units after each edge. Every result is therefore checked in the cycle it is due, and no stray pulse goes unnoticed in any other cycle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_ZERO = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam int STAT_W    = 3;
    localparam int STAT_PERR = 0;
    localparam int STAT_FERR = 1;
    localparam int STAT_OVR  = 2;

endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (div_i <= DIV_W'(1)) || (cnt_q >= div_i - DIV_W'(1));
        cnt_d  = tick_o ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  par_mode_e         par_mode_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o
);

    localparam int OVS_W = $clog2(OVS);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [OVS_W-1:0] MID_TICK = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] END_TICK = OVS_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [OVS_W-1:0]  ovs;
        logic [BIT_W-1:0]  nbit;
        logic [DATA_W-1:0] shreg;
        logic              pbit;
    } fsm_t;

    fsm_t s_d, s_q;
    logic exp_par;

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        perr_o = 1'b0;
        ferr_o = 1'b0;
        unique case (par_mode_i)
            PAR_EVEN: exp_par = ^s_q.shreg;
            PAR_ODD:  exp_par = ~^s_q.shreg;
            default:  exp_par = 1'b0;
        endcase
        if (tick_i) begin
            unique case (s_q.state)
                ST_IDLE: begin
                    if (!rx_i) begin
                        s_d.state = ST_START;
                        s_d.ovs   = '0;
                    end
                end
                ST_START: begin
                    if (s_q.ovs == MID_TICK) begin
                        s_d.ovs   = '0;
                        s_d.nbit  = '0;
                        s_d.state = rx_i ? ST_IDLE : ST_DATA;
                    end else begin
                        s_d.ovs = s_q.ovs + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (s_q.ovs == END_TICK) begin
                        s_d.ovs   = '0;
                        s_d.shreg = {rx_i, s_q.shreg[DATA_W-1:1]};
                        if (s_q.nbit == LAST_BIT)
                            s_d.state = (par_mode_i == PAR_NONE) ? ST_STOP : ST_PAR;
                        else
                            s_d.nbit = s_q.nbit + 1'b1;
                    end else begin
                        s_d.ovs = s_q.ovs + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (s_q.ovs == END_TICK) begin
                        s_d.ovs   = '0;
                        s_d.pbit  = rx_i;
                        s_d.state = ST_STOP;
                    end else begin
                        s_d.ovs = s_q.ovs + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (s_q.ovs == END_TICK) begin
                        done_o    = 1'b1;
                        ferr_o    = !rx_i;
                        perr_o    = (par_mode_i != PAR_NONE) && (s_q.pbit != exp_par);
                        s_d.ovs   = '0;
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.ovs = s_q.ovs + 1'b1;
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
        data_o = s_q.shreg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.ovs   <= '0;
            s_q.nbit  <= '0;
            s_q.shreg <= '0;
            s_q.pbit  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/uart_rx_errroute.sv
module uart_rx_errroute
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic [DIV_W-1:0]  baud_div_i,
    input  logic [1:0]        parity_mode_i,
    input  logic              err_merge_i,
    input  logic              rd_buf_i,
    input  logic              rd_stat_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              buf_full_o,
    output logic [2:0]        stat_o,
    output logic              irq_done_o,
    output logic              irq_err_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [DATA_W-1:0]      data;
        logic                   full;
        logic [STAT_W-1:0]      stat;
        logic                   irq_done;
        logic                   irq_err;
    } top_t;

    top_t r_d, r_q;

    logic              tick;
    logic              fr_done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_perr;
    logic              fr_ferr;
    logic [STAT_W-1:0] flags;
    logic              ovr;

    rx_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (baud_div_i),
        .tick_o (tick)
    );

    rx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .rx_i       (r_q.sync[SYNC_STAGES-1]),
        .par_mode_i (par_mode_e'(parity_mode_i)),
        .done_o     (fr_done),
        .data_o     (fr_data),
        .perr_o     (fr_perr),
        .ferr_o     (fr_ferr)
    );

    always_comb begin
        r_d          = r_q;
        r_d.sync     = {r_q.sync[SYNC_STAGES-2:0], rx_i};
        r_d.irq_done = 1'b0;
        r_d.irq_err  = 1'b0;
        ovr          = fr_done && r_q.full && !rd_buf_i;
        flags        = '0;
        flags[STAT_PERR] = fr_perr;
        flags[STAT_FERR] = fr_ferr;
        flags[STAT_OVR]  = ovr;
        if (rd_buf_i)  r_d.full = 1'b0;
        if (rd_stat_i) r_d.stat = '0;
        if (fr_done) begin
            r_d.stat = r_d.stat | flags;
            if (!ovr) begin
                r_d.data = fr_data;
                r_d.full = 1'b1;
            end
            if (err_merge_i) begin
                r_d.irq_done = 1'b1;
            end else begin
                r_d.irq_done = ~|flags;
                r_d.irq_err  = |flags;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sync     <= '1;
            r_q.data     <= '0;
            r_q.full     <= 1'b0;
            r_q.stat     <= '0;
            r_q.irq_done <= 1'b0;
            r_q.irq_err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data_o  = r_q.data;
    assign buf_full_o = r_q.full;
    assign stat_o     = r_q.stat;
    assign irq_done_o = r_q.irq_done;
    assign irq_err_o  = r_q.irq_err;

endmodule

// File: rtl/uart_rx_errroute_chk.sv
module uart_rx_errroute_chk
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        parity_mode_i,
    input logic              err_merge_i,
    input logic              rd_buf_i,
    input logic              rd_stat_i,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              buf_full_o,
    input logic [2:0]        stat_o,
    input logic              irq_done_o,
    input logic              irq_err_o
);

    // R7
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_done_o && irq_err_o));

    // R8
    merge_no_err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_merge_i |-> !irq_err_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done_o |=> !irq_done_o);

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err_o |=> !irq_err_o);

    // R7
    err_irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err_o |-> (stat_o != 3'b000));

    // R6
    stat_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_i |=> (stat_o == 3'b000) || irq_done_o || irq_err_o);

    // R5
    overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full_o && !rd_buf_i) |=> $stable(rx_data_o));

    // R3
    no_parity_no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[STAT_PERR]) |-> ($past(parity_mode_i) != PAR_NONE));

endmodule

bind uart_rx_errroute uart_rx_errroute_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_uart_rx_errroute.sv
module tb_uart_rx_errroute;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] baud_div = 8'd1;
    logic [1:0] pmode = 2'd0;
    logic       merge = 1'b0;
    logic       rd_buf = 1'b0;
    logic       rd_stat = 1'b0;
    logic [7:0] rx_data;
    logic       buf_full;
    logic [2:0] stat;
    logic       irq_done;
    logic       irq_err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_errroute dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_i          (rx),
        .baud_div_i    (baud_div),
        .parity_mode_i (pmode),
        .err_merge_i   (merge),
        .rd_buf_i      (rd_buf),
        .rd_stat_i     (rd_stat),
        .rx_data_o     (rx_data),
        .buf_full_o    (buf_full),
        .stat_o        (stat),
        .irq_done_o    (irq_done),
        .irq_err_o     (irq_err)
    );

    typedef struct {
        int       at;
        bit [7:0] d;
        bit       pe;
        bit       fe;
    } ev_t;

    ev_t evq[$];

    bit [7:0] m_data;
    bit       m_full;
    bit [2:0] m_stat;
    bit       m_idone;
    bit       m_ierr;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, stepped at every edge, compared after it
    always @(posedge clk) begin
        #2;
        cyc++;
        m_idone = 0;
        m_ierr  = 0;
        if (!rst_n) begin
            m_data = 0; m_full = 0; m_stat = 0;
        end else begin
            bit   have;
            ev_t  e;
            bit   ov;
            bit [2:0] f;
            have = 0;
            if (evq.size() > 0 && evq[0].at == cyc) begin
                e = evq.pop_front();
                have = 1;
            end
            ov = have && m_full && !rd_buf;
            if (rd_buf)  m_full = 0;
            if (rd_stat) m_stat = 0;
            if (have) begin
                f = {ov, e.fe, e.pe};
                m_stat = m_stat | f;
                if (!ov) begin m_data = e.d; m_full = 1; end
                if (merge) m_idone = 1;
                else begin m_idone = (f == 0); m_ierr = (f != 0); end
            end
        end
        if (!rst_n) begin
            chk(rx_data == 0 && buf_full == 0 && stat == 0 && !irq_done && !irq_err,
                "R10 reset outputs", {rx_data, buf_full, stat, irq_done, irq_err}, 0);
        end else begin
            chk(rx_data == m_data, "R2 buffer data", rx_data, m_data);
            chk(buf_full == m_full, "R2 buffer full", buf_full, m_full);
            chk(stat[0] == m_stat[0], "R3 parity flag", stat[0], m_stat[0]);
            chk(stat[1] == m_stat[1], "R4 framing flag", stat[1], m_stat[1]);
            chk(stat[2] == m_stat[2], "R5 overrun flag", stat[2], m_stat[2]);
            chk(irq_done == m_idone, merge ? "R9 R8 done irq" : "R9 R7 done irq", irq_done, m_idone);
            chk(irq_err == m_ierr, merge ? "R9 R8 err irq" : "R9 R7 err irq", irq_err, m_ierr);
        end
    end

    task automatic hold(bit v);
        rx = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(bit [7:0] d, bit bad_par, bit stop_ok);
        int  k, n;
        bit  p;
        ev_t e;
        @(negedge clk);
        k = cyc;
        n = (pmode == 2'd0) ? 8 : 9;
        case (pmode)
            2'd1: p = ^d;
            2'd2: p = ~^d;
            default: p = 1'b0;
        endcase
        p ^= bad_par;
        e.at = k + 27 + 16 * n;
        e.d  = d;
        e.pe = (pmode != 2'd0) && bad_par;
        e.fe = !stop_ok;
        evq.push_back(e);
        hold(1'b0);
        for (int i = 0; i < 8; i++) hold(d[i]);
        if (pmode != 2'd0) hold(p);
        hold(stop_ok);
        rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_buf();
        @(negedge clk) rd_buf = 1'b1;
        @(negedge clk) rd_buf = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk) rd_stat = 1'b1;
        @(negedge clk) rd_stat = 1'b0;
        chk(stat == 3'b000, "R6 status cleared by read", stat, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R2 R7: clean even-parity frame
        pmode = 2'd1;
        send(8'hA5, 0, 1);
        chk(rx_data == 8'hA5, "R2 byte delivered", rx_data, 8'hA5);
        read_buf();

        // R3 R7: odd parity with wrong parity bit
        pmode = 2'd2;
        send(8'h3C, 1, 1);
        read_stat();
        read_buf();

        // R3: no parity, flipped bit request is meaningless
        pmode = 2'd0;
        send(8'h81, 1, 1);
        chk(stat[0] == 1'b0, "R3 no parity never flags", stat[0], 0);
        read_buf();

        // R3: forced-zero parity, good then bad
        pmode = 2'd3;
        send(8'h55, 0, 1);
        read_buf();
        send(8'h0F, 1, 1);
        read_stat();
        read_buf();

        // R4: framing error, byte still stored
        pmode = 2'd1;
        send(8'hC3, 0, 0);
        chk(rx_data == 8'hC3, "R4 byte kept on framing error", rx_data, 8'hC3);
        read_stat();
        read_buf();

        // R5: overrun keeps earlier byte
        send(8'h11, 0, 1);
        send(8'h22, 0, 1);
        chk(rx_data == 8'h11, "R5 earlier byte kept", rx_data, 8'h11);
        chk(stat[2] == 1'b1, "R5 overrun flag set", stat[2], 1);
        read_stat();
        read_buf();

        // R1: short low glitch starts no frame
        @(negedge clk) rx = 1'b0;
        repeat (5) @(negedge clk);
        rx = 1'b1;
        repeat (60) @(negedge clk);
        chk(buf_full == 1'b0, "R1 glitch ignored", buf_full, 0);

        // R8: merged routing, error then clean
        merge = 1'b1;
        send(8'h5A, 1, 1);
        read_stat();
        read_buf();
        send(8'h99, 0, 1);
        read_buf();
        read_stat();

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule